// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sequences the low-power states of a small 8-bit processor core. The core gives it a one-cycle pulse when a WAIT or a STOP instruction executes. A configuration bit selects what STOP does: it either enters a true stop or is turned into a halt state, which keeps the timer and watchdog clocks running. In every low-power state the sequencer removes the CPU/bus clock enable. On entry it pulses a clear of the interrupt mask bit, so an external interrupt can end the state.

The wake rules depend on the state. Wait returns to run on the cycle after a wake request. Halt and stop do not start a fresh delay when they exit. They wait for the next terminal count of a stabilization counter that has run freely since reset, so the wake latency falls anywhere between 1 and the counter's length. A reset, from the external pin or from a watchdog timeout, overrides everything. It returns the block to run at once and sets the interrupt mask. The block never resets or clears any register, memory or I/O state when a low-power state begins or ends.

Top module: `lowpower_seq`

## Requirements
- R1: While `rstN` is low, and on the cycle after it is sampled low, `lpState` is 2'b00 (run), `cpuClkEn` is 1 and `maskSet` is 1. The stabilization counter restarts at 0 on that edge.
- R2: In run, a `waitExec` pulse sets `lpState` to 2'b01 (wait) on the next cycle. In wait `cpuClkEn` is 0 and both `timerClkEn` and `wdogClkEn` are 1.
- R3: In run with `cfgStopToHalt`=1, a `stopExec` pulse sets `lpState` to 2'b10 (halt) on the next cycle. In halt `cpuClkEn` is 0 and both `timerClkEn` and `wdogClkEn` are 1.
- R4: In run with `cfgStopToHalt`=0, a `stopExec` pulse sets `lpState` to 2'b11 (stop). In stop `cpuClkEn`, `timerClkEn` and `wdogClkEn` are all 0.
- R5: `maskClr` is high for exactly one cycle, the first cycle of any low-power state entered by an instruction pulse.
- R6: In wait, a high `timerIrq` or `extIrq`, or a high `portIrq` while `cfgPortWake`=1, returns `lpState` to run on the next cycle.
- R7: `portIrq` has no effect on any state while `cfgPortWake`=0.
- R8: In halt, the wake sources of R6 are remembered once seen. The block returns to run on the first clock edge at which a wake has been seen (on that edge or earlier) and the stabilization counter holds its terminal value `STAB_LEN-1`. The counter counts 0 to `STAB_LEN-1` once per cycle from reset, so exit takes 1 to `STAB_LEN` cycles.
- R9: In stop, only `extIrq`, and `portIrq` while `cfgPortWake`=1, wake the block. `timerIrq` is ignored. Exit follows the terminal-count rule of R8.
- R10: A high `wdogTimeout` acts as a reset, exactly as `rstN`=0 does. A reset from either source takes priority over every wake condition and every pending exit.
- R11: `wakePulse` is high for exactly one cycle, the first run cycle after a wake exit. It stays low after a reset.
- R12: `waitExec` and `stopExec` are ignored outside run. If both are high in run, WAIT wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous external reset, active low |
| wdogTimeout | input | 1 | Watchdog timeout; acts as a reset |
| waitExec | input | 1 | WAIT instruction executed (pulse) |
| stopExec | input | 1 | STOP instruction executed (pulse) |
| cfgStopToHalt | input | 1 | 1: STOP enters halt; 0: STOP enters stop |
| cfgPortWake | input | 1 | 1: port interrupt may wake the block |
| timerIrq | input | 1 | Enabled timer interrupt request |
| extIrq | input | 1 | External IRQ request |
| portIrq | input | 1 | Port interrupt request |
| cpuClkEn | output | 1 | CPU/bus clock enable |
| timerClkEn | output | 1 | Timer clock enable |
| wdogClkEn | output | 1 | Watchdog clock enable |
| maskClr | output | 1 | Clear interrupt mask (one-cycle pulse) |
| maskSet | output | 1 | Set interrupt mask (after reset) |
| wakePulse | output | 1 | Start of interrupt vector fetch |
| lpState | output | 2 | 00 run, 01 wait, 10 halt, 11 stop |

## Verification
Every result is due at a fixed distance from the edge that samples its stimulus. State changes, `maskClr`, `maskSet` and `wakePulse` appear in the cycle after that edge. The clock enables follow the state in that same cycle. A halt or stop exit waits for the counter's terminal count, so it lands between 1 and `STAB_LEN` cycles later. The bench keeps its own behavioural count of cycles since reset. It drives inputs on falling edges, advances its model on rising edges and compares every output on the next falling edge. Directed checks time wake requests at counter values 0 and `STAB_LEN-1` and expect exits after exactly `STAB_LEN` cycles and after exactly 1 cycle.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [1:0] {
    LP_RUN  = 2'b00,
    LP_WAIT = 2'b01,
    LP_HALT = 2'b10,
    LP_STOP = 2'b11
  } lpState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic hwReset;   // reset from any source this cycle
    logic enterLp;   // leaving run for a low-power state
    logic wakeExit;  // leaving a low-power state on a wake
    logic armPend;   // remember a wake seen before terminal count
  } seqStrobe_t;

endpackage

// File: rtl/lps_dp.sv
module lps_dp
  import lps_pkg::*;
#(
  parameter int STAB_LEN = 4064
) (
  input  logic       clk,
  input  seqStrobe_t strobe,
  input  logic       cfgPortWake,
  input  logic       timerIrq,
  input  logic       extIrq,
  input  logic       portIrq,
  output logic       termHit,
  output logic       pendQ,
  output logic       wakeAll,
  output logic       wakeNoTimer,
  output logic       maskClr,
  output logic       maskSet,
  output logic       wakePulse
);

  localparam int CNT_W = (STAB_LEN > 1) ? $clog2(STAB_LEN) : 1;
  localparam logic [CNT_W-1:0] TERM_VAL = CNT_W'(STAB_LEN - 1);

  logic [CNT_W-1:0] stabCnt;

  // free-running stabilization counter, restarted only by reset
  always_ff @(posedge clk) begin
    if (strobe.hwReset || termHit) stabCnt <= '0;
    else                           stabCnt <= stabCnt + 1'b1;
  end

  assign termHit = (stabCnt == TERM_VAL);

  // wake source qualification
  logic portOk;
  assign portOk      = cfgPortWake & portIrq;
  assign wakeNoTimer = extIrq | portOk;
  assign wakeAll     = wakeNoTimer | timerIrq;

  // remembered wake request for halt/stop
  always_ff @(posedge clk) begin
    if (strobe.hwReset || strobe.wakeExit) pendQ <= 1'b0;
    else if (strobe.armPend)               pendQ <= 1'b1;
  end

  // one-cycle pulses toward the core
  always_ff @(posedge clk) begin
    maskSet   <= strobe.hwReset;
    maskClr   <= strobe.enterLp & ~strobe.hwReset;
    wakePulse <= strobe.wakeExit & ~strobe.hwReset;
  end

endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
(
  input  logic       clk,
  input  logic       hwReset,
  input  logic       waitExec,
  input  logic       stopExec,
  input  logic       cfgStopToHalt,
  input  logic       termHit,
  input  logic       pendQ,
  input  logic       wakeAll,
  input  logic       wakeNoTimer,
  output seqStrobe_t strobe,
  output lpState_e   stateQ
);

  lpState_e nextState;
  logic     reqSeen;

  always_comb begin
    nextState       = stateQ;
    strobe          = '0;
    strobe.hwReset  = hwReset;
    reqSeen         = 1'b0;
    if (hwReset) begin
      nextState = LP_RUN;
    end else begin
      unique case (stateQ)
        LP_RUN: begin
          if (waitExec) begin
            nextState      = LP_WAIT;
            strobe.enterLp = 1'b1;
          end else if (stopExec) begin
            nextState      = cfgStopToHalt ? LP_HALT : LP_STOP;
            strobe.enterLp = 1'b1;
          end
        end
        LP_WAIT: begin
          if (wakeAll) begin
            nextState       = LP_RUN;
            strobe.wakeExit = 1'b1;
          end
        end
        LP_HALT, LP_STOP: begin
          reqSeen = pendQ | ((stateQ == LP_HALT) ? wakeAll : wakeNoTimer);
          if (reqSeen && termHit) begin
            nextState       = LP_RUN;
            strobe.wakeExit = 1'b1;
          end else if (reqSeen) begin
            strobe.armPend = 1'b1;
          end
        end
        default: nextState = LP_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) stateQ <= nextState;

endmodule

// File: rtl/lowpower_seq.sv
module lowpower_seq
  import lps_pkg::*;
#(
  parameter int STAB_LEN = 4064
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wdogTimeout,
  input  logic       waitExec,
  input  logic       stopExec,
  input  logic       cfgStopToHalt,
  input  logic       cfgPortWake,
  input  logic       timerIrq,
  input  logic       extIrq,
  input  logic       portIrq,
  output logic       cpuClkEn,
  output logic       timerClkEn,
  output logic       wdogClkEn,
  output logic       maskClr,
  output logic       maskSet,
  output logic       wakePulse,
  output logic [1:0] lpState
);

  seqStrobe_t strobe;
  lpState_e   stateQ;
  logic       hwReset, termHit, pendQ, wakeAll, wakeNoTimer;

  assign hwReset = ~rstN | wdogTimeout;

  lps_ctrl uCtrl (
    .clk          (clk),
    .hwReset      (hwReset),
    .waitExec     (waitExec),
    .stopExec     (stopExec),
    .cfgStopToHalt(cfgStopToHalt),
    .termHit      (termHit),
    .pendQ        (pendQ),
    .wakeAll      (wakeAll),
    .wakeNoTimer  (wakeNoTimer),
    .strobe       (strobe),
    .stateQ       (stateQ)
  );

  lps_dp #(.STAB_LEN(STAB_LEN)) uDp (
    .clk        (clk),
    .strobe     (strobe),
    .cfgPortWake(cfgPortWake),
    .timerIrq   (timerIrq),
    .extIrq     (extIrq),
    .portIrq    (portIrq),
    .termHit    (termHit),
    .pendQ      (pendQ),
    .wakeAll    (wakeAll),
    .wakeNoTimer(wakeNoTimer),
    .maskClr    (maskClr),
    .maskSet    (maskSet),
    .wakePulse  (wakePulse)
  );

  assign lpState    = stateQ;
  assign cpuClkEn   = (stateQ == LP_RUN);
  assign timerClkEn = (stateQ != LP_STOP);
  assign wdogClkEn  = (stateQ != LP_STOP);

endmodule

// File: rtl/lps_checker.sv
module lps_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wdogTimeout,
  input logic       cfgPortWake,
  input logic       timerIrq,
  input logic       extIrq,
  input logic       cpuClkEn,
  input logic       timerClkEn,
  input logic       wdogClkEn,
  input logic       maskClr,
  input logic       maskSet,
  input logic       wakePulse,
  input logic [1:0] lpState
);

  logic armed;
  always_ff @(posedge clk) armed <= 1'b1;

  logic hw;
  assign hw = !rstN || wdogTimeout;

  AST_RESET_RUN: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    hw |=> (lpState == 2'b00 && maskSet && cpuClkEn && !wakePulse)); // R10
  AST_WAIT_ENABLES: assert property (@(posedge clk) disable iff (armed !== 1'b1 || hw)
    lpState == 2'b01 |-> (!cpuClkEn && timerClkEn && wdogClkEn)); // R2
  AST_HALT_ENABLES: assert property (@(posedge clk) disable iff (armed !== 1'b1 || hw)
    lpState == 2'b10 |-> (!cpuClkEn && timerClkEn && wdogClkEn)); // R3
  AST_STOP_ENABLES: assert property (@(posedge clk) disable iff (armed !== 1'b1 || hw)
    lpState == 2'b11 |-> (!cpuClkEn && !timerClkEn && !wdogClkEn)); // R4
  AST_MASKCLR_SINGLE: assert property (@(posedge clk) disable iff (armed !== 1'b1 || hw)
    maskClr |=> !maskClr); // R5
  AST_MASKCLR_ENTRY: assert property (@(posedge clk) disable iff (armed !== 1'b1 || hw)
    maskClr |-> (lpState != 2'b00 && $past(lpState) == 2'b00)); // R5
  AST_WAIT_WAKE: assert property (@(posedge clk) disable iff (armed !== 1'b1 || hw)
    (lpState == 2'b01 && (timerIrq || extIrq)) |=> lpState == 2'b00); // R6
  AST_PORT_MASKED: assert property (@(posedge clk) disable iff (armed !== 1'b1 || hw)
    (lpState == 2'b01 && !timerIrq && !extIrq && !cfgPortWake) |=> lpState == 2'b01); // R7
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (armed !== 1'b1 || hw)
    wakePulse |-> (cpuClkEn && $past(lpState) != 2'b00)); // R11

endmodule

bind lowpower_seq lps_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .wdogTimeout(wdogTimeout),
  .cfgPortWake(cfgPortWake),
  .timerIrq   (timerIrq),
  .extIrq     (extIrq),
  .cpuClkEn   (cpuClkEn),
  .timerClkEn (timerClkEn),
  .wdogClkEn  (wdogClkEn),
  .maskClr    (maskClr),
  .maskSet    (maskSet),
  .wakePulse  (wakePulse),
  .lpState    (lpState)
);

// File: tb/lowpower_seq_test.sv
module lowpower_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int STAB = 4064;

  logic clk = 1'b0;
  logic rstN = 1'b0, wdogTimeout = 1'b0, waitExec = 1'b0, stopExec = 1'b0;
  logic cfgStopToHalt = 1'b0, cfgPortWake = 1'b0;
  logic timerIrq = 1'b0, extIrq = 1'b0, portIrq = 1'b0;
  logic cpuClkEn, timerClkEn, wdogClkEn, maskClr, maskSet, wakePulse;
  logic [1:0] lpState;

  int total = 0, bad = 0, cycles = 0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  lowpower_seq #(.STAB_LEN(STAB)) uut (
    .clk(clk), .rstN(rstN), .wdogTimeout(wdogTimeout), .waitExec(waitExec),
    .stopExec(stopExec), .cfgStopToHalt(cfgStopToHalt), .cfgPortWake(cfgPortWake),
    .timerIrq(timerIrq), .extIrq(extIrq), .portIrq(portIrq),
    .cpuClkEn(cpuClkEn), .timerClkEn(timerClkEn), .wdogClkEn(wdogClkEn),
    .maskClr(maskClr), .maskSet(maskSet), .wakePulse(wakePulse), .lpState(lpState));

  // behavioural reference model
  int mState = 0, mCnt = 0;
  bit mPend = 0, mMaskClr = 0, mMaskSet = 0, mWake = 0, modelValid = 0;

  always @(posedge clk) begin
    bit wakeA, wakeS, term, req;
    wakeA = timerIrq || extIrq || (cfgPortWake && portIrq);
    wakeS = extIrq || (cfgPortWake && portIrq);
    if (!rstN || wdogTimeout) begin
      mState = 0; mCnt = 0; mPend = 0;
      mMaskSet = 1; mMaskClr = 0; mWake = 0; modelValid = 1;
    end else if (modelValid) begin
      term = (mCnt == STAB - 1);
      mCnt = term ? 0 : mCnt + 1;
      mMaskSet = 0; mMaskClr = 0; mWake = 0;
      case (mState)
        0: if (waitExec) begin mState = 1; mMaskClr = 1; end
           else if (stopExec) begin mState = cfgStopToHalt ? 2 : 3; mMaskClr = 1; end
        1: if (wakeA) begin mState = 0; mWake = 1; end
        default: begin
          req = mPend || ((mState == 2) ? wakeA : wakeS);
          if (req && term) begin mState = 0; mWake = 1; mPend = 0; end
          else if (req) mPend = 1;
        end
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // every-cycle comparison
  always @(negedge clk) begin
    cycles++;
    if (modelValid) begin
      check(lpState == 2'(mState), curReq, "lpState", int'(lpState), mState);
      check(cpuClkEn == (mState == 0), curReq, "cpuClkEn", int'(cpuClkEn), int'(mState == 0));
      check(timerClkEn == (mState != 3), curReq, "timerClkEn", int'(timerClkEn), int'(mState != 3));
      check(wdogClkEn == (mState != 3), curReq, "wdogClkEn", int'(wdogClkEn), int'(mState != 3));
      check(maskClr == mMaskClr, curReq, "maskClr", int'(maskClr), int'(mMaskClr));
      check(maskSet == mMaskSet, curReq, "maskSet", int'(maskSet), int'(mMaskSet));
      check(wakePulse == mWake, curReq, "wakePulse", int'(wakePulse), int'(mWake));
    end
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; tick(1); sig = 1'b0;
  endtask

  task automatic waitRun(output int n);
    n = 0;
    do begin tick(1); n++; end while (lpState != 2'b00 && n < STAB + 10);
  endtask

  initial begin
    int n;
    // R1 reset
    curReq = "R1";
    tick(3);
    check(lpState == 2'b00 && cpuClkEn && maskSet, "R1", "reset state", int'(lpState), 0);
    rstN = 1'b1; tick(1);
    check(maskSet == 1'b0, "R1", "maskSet after release", int'(maskSet), 0);

    // R2 / R5 / R6 wait entry and exit on extIrq
    curReq = "R2";
    pulse(waitExec);
    check(lpState == 2'b01 && maskClr, "R2", "wait entry", int'(lpState), 1);
    tick(1);
    check(maskClr == 1'b0, "R5", "maskClr single cycle", int'(maskClr), 0);
    curReq = "R6";
    tick(4); pulse(extIrq);
    check(lpState == 2'b00 && wakePulse, "R6", "wait exit on extIrq", int'(lpState), 0);
    tick(1);
    check(wakePulse == 1'b0, "R11", "wakePulse single cycle", int'(wakePulse), 0);

    // R7 port masked, then enabled
    curReq = "R7";
    pulse(waitExec);
    portIrq = 1'b1; tick(3); portIrq = 1'b0;
    check(lpState == 2'b01, "R7", "port ignored when disabled", int'(lpState), 1);
    cfgPortWake = 1'b1; pulse(portIrq);
    check(lpState == 2'b00, "R6", "wait exit on port", int'(lpState), 0);
    cfgPortWake = 1'b0;

    // R12 both exec pulses: wait wins; stop ignored in wait
    curReq = "R12";
    cfgStopToHalt = 1'b1;
    waitExec = 1'b1; stopExec = 1'b1; tick(1); waitExec = 1'b0; stopExec = 1'b0;
    check(lpState == 2'b01, "R12", "wait priority", int'(lpState), 1);
    pulse(stopExec);
    check(lpState == 2'b01, "R12", "stop ignored in wait", int'(lpState), 1);
    pulse(timerIrq);

    // R3 / R8 halt with timer wake
    curReq = "R8";
    pulse(stopExec);
    check(lpState == 2'b10 && timerClkEn && !cpuClkEn, "R3", "halt entry", int'(lpState), 2);
    tick(20); pulse(timerIrq);
    waitRun(n);
    check(lpState == 2'b00, "R8", "halt exit", int'(lpState), 0);

    // R8 fastest exit: request while counter at terminal value
    pulse(stopExec);
    while (mCnt != STAB - 1) tick(1);
    extIrq = 1'b1; tick(1); extIrq = 1'b0;
    check(lpState == 2'b00 && wakePulse, "R8", "exit latency 1", int'(lpState), 0);

    // R8 slowest exit: request while counter at zero
    pulse(stopExec);
    while (mCnt != 0) tick(1);
    extIrq = 1'b1; tick(1); extIrq = 1'b0;
    n = 1;
    while (lpState != 2'b00 && n < STAB + 10) begin tick(1); n++; end
    check(n == STAB, "R8", "exit latency max", n, STAB);

    // R4 / R9 stop: timer ignored across a terminal count, extIrq wakes
    curReq = "R9";
    cfgStopToHalt = 1'b0;
    pulse(stopExec);
    check(lpState == 2'b11 && !timerClkEn && !wdogClkEn, "R4", "stop entry", int'(lpState), 3);
    timerIrq = 1'b1; tick(STAB + 5); timerIrq = 1'b0;
    check(lpState == 2'b11, "R9", "timer ignored in stop", int'(lpState), 3);
    pulse(extIrq);
    waitRun(n);
    check(lpState == 2'b00, "R9", "stop exit on extIrq", int'(lpState), 0);

    // R10 watchdog reset overrides pending halt exit
    curReq = "R10";
    cfgStopToHalt = 1'b1;
    pulse(stopExec);
    pulse(extIrq);
    tick(3);
    pulse(wdogTimeout);
    check(lpState == 2'b00 && maskSet && !wakePulse, "R10", "watchdog reset", int'(lpState), 0);
    check(wakePulse == 1'b0, "R11", "no wakePulse after reset", int'(wakePulse), 0);
    tick(STAB + 5);
    check(lpState == 2'b00, "R10", "stays in run", int'(lpState), 0);

    // R1 external reset from wait
    curReq = "R1";
    pulse(waitExec);
    rstN = 1'b0; tick(1); rstN = 1'b1;
    check(lpState == 2'b00 && maskSet, "R1", "reset from wait", int'(lpState), 0);
    tick(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule